// File: doc/BRIEF.md
# Miss Handling Register Entry

This block is the control for a single outstanding cache miss. It holds the miss address, an ordering tag and five state bits: in-service, below-pending, pending-dirty, post-invalidate and post-downgrade. It keeps two target lists of up to `DEPTH` entries each, a primary list and a deferred list. A target is a command code, a source tag and an ordering tag. Seven operations drive the entry: allocate a miss, add a target, issue the request, take a snoop, take a fill, promote the deferred list and free the entry. Two further strobes set and clear below-pending.

The entry decides where each new requester waits. A target that the issued request cannot serve goes to the deferred list. A snoop that arrives after issue is compared with the request for ordering. It can be queued for replay, leave a pending downgrade or invalidation, or be ignored. When a fill grants exclusive ownership that nobody has taken away, the deferred list is merged back into the primary list. For each snoop the block reports in the same cycle whether it absorbed the snoop and whether shared or memory-inhibit must be raised.

Targets leave through a valid/ready stream that carries the head of the primary list. `tgt_valid` is high when the entry is allocated, the primary list is not empty and no operation strobe is active. A target is consumed in a cycle where `tgt_valid` and `tgt_ready` are both high. Any strobe holds the stream back, because the strobe's operation takes that cycle, and `tgt_valid` may then drop before a transfer. The fields stay stable while `tgt_valid` is high and `tgt_ready` is low.

Top module: `mhr_entry`

## Requirements
- R1: Allocate on a free entry has these effects. It loads the address and ordering tag and clears in-service, below-pending, pending-dirty, post-invalidate and post-downgrade. It leaves exactly one target, in the primary list. That target's source is prefetcher (1) if the command is PREFETCH (5) and CPU (0) otherwise. Allocate on an allocated entry raises `op_err` for one cycle and changes nothing.
- R2: Commands READX (1), UPG (2), SCUPG (3), SC (4) and SCUPG_NG (6) need exclusive. After issue, an added target goes to the deferred list if any of these holds: the deferred list is non-empty, post-invalidate is set, or it needs exclusive while pending-dirty is clear or post-downgrade is set. In every other case, and always before issue, it goes to the primary list with source CPU.
- R3: A target added to the deferred list while post-invalidate is set has its command rewritten before storage: UPG becomes READX, SCUPG becomes SCUPG_NG (6), SC becomes SC_NG (7). Other commands are kept.
- R4: Issue sets in-service. It sets pending-dirty if a non-snoop target that needs exclusive has entered the primary list, or if the response shows inhibit without shared. It clears post-invalidate and post-downgrade. Issue while in service raises `op_err`.
- R5: A snoop is not absorbed, and raises neither shared nor inhibit, in two cases: when the entry is not in service, or when it is marked express while below-pending is set. If such a snoop needs exclusive, both lists have their upgrade commands rewritten as in R3.
- R6: An in-service snoop that needs exclusive rewrites upgrades in the deferred list only. If post-invalidate is already set, the snoop is absorbed and nothing else changes.
- R7: In the remaining cases the snoop is absorbed. If pending-dirty is set or the snoop is an invalidate, a copy with source SNOOP (2) is appended to the primary list, and inhibit is raised only when pending-dirty is set. If that copy was appended and the snoop needs exclusive, post-invalidate is set.
- R8: An absorbed snoop that does not need exclusive, on an entry without post-invalidate, sets post-downgrade and raises shared.
- R9: Promote with an empty primary list and a non-empty deferred list swaps the lists and empties the new deferred list. It takes the ordering tag from the new head target and clears in-service. Promote with a non-empty primary list raises `op_err` and changes nothing.
- R10: A fill merges the lists when four things hold: shared is not asserted, neither post bit is set, and the deferred list holds a target that needs exclusive. The merge appends the deferred targets in order behind the primary targets, marks the primary list exclusive and empties the deferred list. Any other fill changes nothing.
- R11: Free is legal only when both lists are empty, and it then releases the entry. Otherwise it raises `op_err` and leaves the entry as it was.
- R12: When several strobes are active, only one acts. The order is snoop, fill, add, allocate, issue, promote, free, below-set, below-clear.
- R13: The primary list leaves through the valid/ready stream in arrival order, one target per transfer, as described above.
- R14: Each list holds at most `DEPTH` targets. An add aimed at a full list raises `op_err` and stores nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_alloc | input | 1 | Allocate a miss |
| op_add | input | 1 | Add a target |
| op_issue | input | 1 | Mark the request as issued |
| op_snoop | input | 1 | Present a snoop |
| op_fill | input | 1 | Present a fill |
| op_promote | input | 1 | Promote the deferred list |
| op_free | input | 1 | Free the entry |
| op_below_set | input | 1 | Set below-pending |
| op_below_clr | input | 1 | Clear below-pending |
| in_addr | input | ADDR_W | Miss address for allocate |
| in_cmd | input | 3 | Command code for allocate, add and snoop |
| in_ord | input | ORD_W | Ordering tag for allocate, add and snoop |
| rsp_shared | input | 1 | Issue response shows shared |
| rsp_inhibit | input | 1 | Issue response shows memory-inhibit |
| snp_excl | input | 1 | Snoop needs exclusive |
| snp_inval | input | 1 | Snoop is an invalidate |
| snp_express | input | 1 | Snoop is express |
| fill_shared | input | 1 | Fill shows shared |
| snp_absorb | output | 1 | Snoop absorbed (same cycle) |
| snp_shared | output | 1 | Raise shared on the snoop (same cycle) |
| snp_inhibit | output | 1 | Raise memory-inhibit on the snoop (same cycle) |
| tgt_valid | output | 1 | Primary head target available |
| tgt_ready | input | 1 | Consumer takes the head target |
| tgt_cmd | output | 3 | Head target command |
| tgt_src | output | 2 | Head target source |
| tgt_ord | output | ORD_W | Head target ordering tag |
| ent_valid | output | 1 | Entry allocated |
| ent_addr | output | ADDR_W | Miss address |
| ent_ord | output | ORD_W | Entry ordering tag |
| in_service | output | 1 | Request issued |
| below_pending | output | 1 | Request buffered below |
| pend_dirty | output | 1 | Ownership expected |
| post_inval | output | 1 | Invalidate after fill |
| post_down | output | 1 | Downgrade after fill |
| prim_count | output | CNT_W | Primary list occupancy |
| def_count | output | CNT_W | Deferred list occupancy |
| op_err | output | 1 | Illegal operation, one-cycle pulse |

## Verification
The assertions take for granted that the caller respects the list capacity. A fill merge must fit both lists into one, and a snoop copy must find room in the primary list. The assertions also rely on a consumer that raises `tgt_ready` only in cycles without an operation strobe. The stimulus satisfies these conditions. No list ever holds more than four targets, a fill comes only after the lists are known to fit together, and the stream is drained one target per idle cycle. Strobes are combined only in the priority scenario, where they are meant to be.

// File: rtl/mhr_pkg.sv
package mhr_pkg;

  localparam int ORD_W = 8;

  typedef enum logic [2:0] {
    CMD_RD       = 3'd0,
    CMD_RDX      = 3'd1,
    CMD_UPG      = 3'd2,
    CMD_SCUPG    = 3'd3,
    CMD_SC       = 3'd4,
    CMD_PF       = 3'd5,
    CMD_SCUPG_NG = 3'd6,
    CMD_SC_NG    = 3'd7
  } cmd_e;

  typedef enum logic [1:0] {
    SRC_CPU = 2'd0,
    SRC_PF  = 2'd1,
    SRC_SNP = 2'd2
  } src_e;

  typedef struct packed {
    cmd_e             cmd;
    src_e             src;
    logic [ORD_W-1:0] ord;
  } tgt_t;

  typedef enum logic [3:0] {
    OP_NONE, OP_SNOOP, OP_FILL, OP_ADD, OP_ALLOC,
    OP_ISSUE, OP_PROMOTE, OP_FREE, OP_BSET, OP_BCLR
  } op_e;

  function automatic logic wants_excl(cmd_e c);
    return (c == CMD_RDX) || (c == CMD_UPG) || (c == CMD_SCUPG) ||
           (c == CMD_SC) || (c == CMD_SCUPG_NG);
  endfunction

  // Turns a command that relies on an existing copy into one that does not.
  function automatic cmd_e demote(cmd_e c);
    case (c)
      CMD_UPG:   return CMD_RDX;
      CMD_SCUPG: return CMD_SCUPG_NG;
      CMD_SC:    return CMD_SC_NG;
      default:   return c;
    endcase
  endfunction

endpackage

// File: rtl/mhr_tlist.sv
module mhr_tlist
  import mhr_pkg::*;
#(
  parameter  int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   push,
  input  tgt_t                   push_tgt,
  input  logic                   pop,
  input  logic                   rewrite,
  input  logic                   append,
  input  logic [CNT_W-1:0]       app_cnt,
  input  tgt_t [DEPTH-1:0]       app_ents,
  input  logic                   set_excl,
  output logic [CNT_W-1:0]       cnt,
  output tgt_t [DEPTH-1:0]       ents,
  output logic                   excl,
  output logic                   full
);

  tgt_t [DEPTH-1:0] ents_q, ents_n;
  logic [CNT_W-1:0] cnt_q;
  logic             ex_q, ex_n;
  int               nc;
  int               base;

  always_comb begin
    ents_n = ents_q;
    nc     = int'(cnt_q);
    ex_n   = ex_q;
    base   = 0;
    if (clr) begin
      nc   = 0;
      ex_n = 1'b0;
    end else begin
      if (rewrite) begin
        for (int i = 0; i < DEPTH; i++)
          ents_n[IDX_W'(i)].cmd = demote(ents_n[IDX_W'(i)].cmd);
      end
      if (pop && nc > 0) begin
        for (int i = 0; i < DEPTH - 1; i++)
          ents_n[IDX_W'(i)] = ents_n[IDX_W'(i + 1)];
        nc = nc - 1;
      end
      if (append) begin
        base = nc;
        for (int i = 0; i < DEPTH; i++) begin
          if (i >= base && (i - base) < int'(app_cnt))
            ents_n[IDX_W'(i)] = app_ents[IDX_W'(i - base)];
        end
        nc = (base + int'(app_cnt) > DEPTH) ? DEPTH : base + int'(app_cnt);
      end
    end
    if (push && nc < DEPTH) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (i == nc) ents_n[IDX_W'(i)] = push_tgt;
      end
      nc = nc + 1;
      if (push_tgt.src != SRC_SNP && wants_excl(push_tgt.cmd)) ex_n = 1'b1;
    end
    if (set_excl) ex_n = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ents_q <= '0;
      cnt_q  <= '0;
      ex_q   <= 1'b0;
    end else begin
      ents_q <= ents_n;
      cnt_q  <= CNT_W'(nc);
      ex_q   <= ex_n;
    end
  end

  assign cnt  = cnt_q;
  assign ents = ents_q;
  assign excl = ex_q;
  assign full = (int'(cnt_q) == DEPTH);

  p_cap_r14: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) <= DEPTH);

  p_clr_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !push) |=> (cnt_q == '0 && !ex_q));

endmodule

// File: rtl/mhr_snoop_dec.sv
module mhr_snoop_dec (
  input  logic active,
  input  logic in_svc,
  input  logic below,
  input  logic pdirty,
  input  logic pinv,
  input  logic express,
  input  logic excl,
  input  logic inval,
  output logic absorb,
  output logic rw_prim,
  output logic rw_def,
  output logic push_copy,
  output logic inhibit,
  output logic set_pinv,
  output logic set_pdown,
  output logic shared
);

  logic early;

  // The snoop is ordered ahead of this miss when the miss is not yet issued
  // or is still waiting in a lower level that forwarded this snoop.
  assign early     = !in_svc || (express && below);
  assign absorb    = active && !early;
  assign rw_prim   = active && early && excl;
  assign rw_def    = active && excl;
  assign push_copy = absorb && !pinv && (pdirty || inval);
  assign inhibit   = push_copy && pdirty;
  assign set_pinv  = push_copy && excl;
  assign set_pdown = absorb && !pinv && !excl;
  assign shared    = set_pdown;

endmodule

// File: rtl/mhr_entry.sv
module mhr_entry
  import mhr_pkg::*;
#(
  parameter  int ADDR_W = 32,
  parameter  int DEPTH  = 4,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_alloc,
  input  logic              op_add,
  input  logic              op_issue,
  input  logic              op_snoop,
  input  logic              op_fill,
  input  logic              op_promote,
  input  logic              op_free,
  input  logic              op_below_set,
  input  logic              op_below_clr,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [2:0]        in_cmd,
  input  logic [ORD_W-1:0]  in_ord,
  input  logic              rsp_shared,
  input  logic              rsp_inhibit,
  input  logic              snp_excl,
  input  logic              snp_inval,
  input  logic              snp_express,
  input  logic              fill_shared,
  output logic              snp_absorb,
  output logic              snp_shared,
  output logic              snp_inhibit,
  output logic              tgt_valid,
  input  logic              tgt_ready,
  output logic [2:0]        tgt_cmd,
  output logic [1:0]        tgt_src,
  output logic [ORD_W-1:0]  tgt_ord,
  output logic              ent_valid,
  output logic [ADDR_W-1:0] ent_addr,
  output logic [ORD_W-1:0]  ent_ord,
  output logic              in_service,
  output logic              below_pending,
  output logic              pend_dirty,
  output logic              post_inval,
  output logic              post_down,
  output logic [CNT_W-1:0]  prim_count,
  output logic [CNT_W-1:0]  def_count,
  output logic              op_err
);

  // ---------------- state ----------------
  logic              vld_q, svc_q, below_q, pdirty_q, pinv_q, pdown_q, sel_q, err_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ORD_W-1:0]  ord_q;

  // ---------------- list banks ----------------
  tgt_t [DEPTH-1:0]  b_ents [2];
  logic [CNT_W-1:0]  b_cnt  [2];
  logic              b_excl [2];
  logic              b_full [2];

  logic [CNT_W-1:0]  pcnt, dcnt;
  logic              p_excl, d_excl, p_full, d_full;
  tgt_t              p_head, d_head;

  assign pcnt   = b_cnt[sel_q];
  assign dcnt   = b_cnt[~sel_q];
  assign p_excl = b_excl[sel_q];
  assign d_excl = b_excl[~sel_q];
  assign p_full = b_full[sel_q];
  assign d_full = b_full[~sel_q];
  assign p_head = b_ents[sel_q][0];
  assign d_head = b_ents[~sel_q][0];

  // ---------------- operation select ----------------
  op_e  op;
  cmd_e cmd_in;
  assign cmd_in = cmd_e'(in_cmd);

  always_comb begin
    if      (op_snoop)     op = OP_SNOOP;
    else if (op_fill)      op = OP_FILL;
    else if (op_add)       op = OP_ADD;
    else if (op_alloc)     op = OP_ALLOC;
    else if (op_issue)     op = OP_ISSUE;
    else if (op_promote)   op = OP_PROMOTE;
    else if (op_free)      op = OP_FREE;
    else if (op_below_set) op = OP_BSET;
    else if (op_below_clr) op = OP_BCLR;
    else                   op = OP_NONE;
  end

  // ---------------- snoop decision ----------------
  logic s_abs, s_rwp, s_rwd, s_copy, s_inh, s_pinv, s_pdown, s_sh;

  mhr_snoop_dec u_snoop (
    .active    (op == OP_SNOOP && vld_q),
    .in_svc    (svc_q),
    .below     (below_q),
    .pdirty    (pdirty_q),
    .pinv      (pinv_q),
    .express   (snp_express),
    .excl      (snp_excl),
    .inval     (snp_inval),
    .absorb    (s_abs),
    .rw_prim   (s_rwp),
    .rw_def    (s_rwd),
    .push_copy (s_copy),
    .inhibit   (s_inh),
    .set_pinv  (s_pinv),
    .set_pdown (s_pdown),
    .shared    (s_sh)
  );

  assign snp_absorb  = s_abs;
  assign snp_shared  = s_sh;
  assign snp_inhibit = s_inh;

  // ---------------- per-role list controls ----------------
  logic p_clr, p_push, p_pop, p_rw, p_app, p_setx;
  logic d_clr, d_push, d_rw;
  tgt_t p_tgt, d_tgt;
  logic to_def, merge_ok, err_c;

  assign merge_ok = !fill_shared && !pinv_q && !pdown_q && d_excl;
  assign to_def   = svc_q && (dcnt != '0 || pinv_q ||
                    (wants_excl(cmd_in) && (!pdirty_q || pdown_q)));

  assign tgt_valid = vld_q && (pcnt != '0) && (op == OP_NONE);
  assign p_pop     = tgt_valid && tgt_ready;

  always_comb begin
    p_clr  = 1'b0; p_push = 1'b0; p_rw = 1'b0; p_app = 1'b0; p_setx = 1'b0;
    d_clr  = 1'b0; d_push = 1'b0; d_rw = 1'b0;
    p_tgt  = '{cmd: cmd_in, src: SRC_CPU, ord: in_ord};
    d_tgt  = '{cmd: cmd_in, src: SRC_CPU, ord: in_ord};
    err_c  = 1'b0;
    case (op)
      OP_ALLOC: begin
        if (vld_q) err_c = 1'b1;
        else begin
          p_clr  = 1'b1;
          p_push = 1'b1;
          p_tgt.src = (cmd_in == CMD_PF) ? SRC_PF : SRC_CPU;
        end
      end
      OP_ADD: begin
        if (vld_q) begin
          if (to_def) begin
            if (d_full) err_c = 1'b1;
            else begin
              d_push = 1'b1;
              if (pinv_q) d_tgt.cmd = demote(cmd_in);
            end
          end else begin
            if (p_full) err_c = 1'b1;
            else p_push = 1'b1;
          end
        end
      end
      OP_SNOOP: begin
        p_rw = s_rwp;
        d_rw = s_rwd;
        if (s_copy) begin
          if (p_full) err_c = 1'b1;
          else begin
            p_push    = 1'b1;
            p_tgt.src = SRC_SNP;
          end
        end
      end
      OP_FILL: begin
        if (vld_q && merge_ok) begin
          p_app  = 1'b1;
          p_setx = 1'b1;
          d_clr  = 1'b1;
        end
      end
      OP_ISSUE: begin
        if (vld_q && svc_q) err_c = 1'b1;
      end
      OP_PROMOTE: begin
        if (vld_q) begin
          if (pcnt != '0) err_c = 1'b1;
          else if (dcnt != '0) p_clr = 1'b1;
        end
      end
      OP_FREE: begin
        if (vld_q && (pcnt != '0 || dcnt != '0)) err_c = 1'b1;
      end
      default: ;
    endcase
  end

  // Bank b plays the primary role when sel_q equals b.
  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic is_p;
    assign is_p = (sel_q == 1'(b));
    mhr_tlist #(.DEPTH(DEPTH)) u_list (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (is_p ? p_clr  : d_clr),
      .push     (is_p ? p_push : d_push),
      .push_tgt (is_p ? p_tgt  : d_tgt),
      .pop      (is_p && p_pop),
      .rewrite  (is_p ? p_rw   : d_rw),
      .append   (is_p && p_app),
      .app_cnt  (b_cnt[1-b]),
      .app_ents (b_ents[1-b]),
      .set_excl (is_p && p_setx),
      .cnt      (b_cnt[b]),
      .ents     (b_ents[b]),
      .excl     (b_excl[b]),
      .full     (b_full[b])
    );
  end

  // ---------------- state update ----------------
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0; svc_q <= 1'b0; below_q <= 1'b0; pdirty_q <= 1'b0;
      pinv_q <= 1'b0; pdown_q <= 1'b0; sel_q <= 1'b0; err_q <= 1'b0;
      addr_q <= '0; ord_q <= '0;
    end else begin
      err_q <= err_c;
      case (op)
        OP_ALLOC: if (!vld_q) begin
          vld_q <= 1'b1; addr_q <= in_addr; ord_q <= in_ord;
          svc_q <= 1'b0; below_q <= 1'b0; pdirty_q <= 1'b0;
          pinv_q <= 1'b0; pdown_q <= 1'b0;
        end
        OP_ISSUE: if (vld_q && !svc_q) begin
          svc_q    <= 1'b1;
          pdirty_q <= p_excl || (rsp_inhibit && !rsp_shared);
          pinv_q   <= 1'b0;
          pdown_q  <= 1'b0;
        end
        OP_SNOOP: begin
          if (s_pinv)  pinv_q  <= 1'b1;
          if (s_pdown) pdown_q <= 1'b1;
        end
        OP_PROMOTE: if (vld_q && pcnt == '0 && dcnt != '0) begin
          sel_q <= ~sel_q;
          ord_q <= d_head.ord;
          svc_q <= 1'b0;
        end
        OP_FREE: if (vld_q && pcnt == '0 && dcnt == '0) begin
          vld_q <= 1'b0;
          svc_q <= 1'b0;
        end
        OP_BSET: if (vld_q) below_q <= 1'b1;
        OP_BCLR: if (vld_q) below_q <= 1'b0;
        default: ;
      endcase
    end
  end

  assign tgt_cmd       = p_head.cmd;
  assign tgt_src       = p_head.src;
  assign tgt_ord       = p_head.ord;
  assign ent_valid     = vld_q;
  assign ent_addr      = addr_q;
  assign ent_ord       = ord_q;
  assign in_service    = svc_q;
  assign below_pending = below_q;
  assign pend_dirty    = pdirty_q;
  assign post_inval    = pinv_q;
  assign post_down     = pdown_q;
  assign prim_count    = pcnt;
  assign def_count     = dcnt;
  assign op_err        = err_q;

  // ---------------- assertions ----------------
  p_alloc_one_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_ALLOC && !vld_q) |=> (prim_count == CNT_W'(1) && def_count == '0 && !in_service));

  p_pinv_defers_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_ADD && vld_q && svc_q && pinv_q) |=> $stable(prim_count));

  p_issue_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_ISSUE && vld_q && !svc_q) |=> (in_service && !post_inval && !post_down));

  p_early_snoop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_snoop && !in_service) |-> (!snp_absorb && !snp_shared && !snp_inhibit));

  p_inhibit_dirty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    snp_inhibit |-> (pend_dirty && snp_absorb));

  p_shared_down_r8: assert property (@(posedge clk) disable iff (!rst_n)
    snp_shared |=> post_down);

  p_promote_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_PROMOTE && vld_q && pcnt != '0) |=> (op_err && $stable(prim_count)));

  p_free_err_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_FREE && vld_q && (pcnt != '0 || dcnt != '0)) |=> (op_err && ent_valid));

  p_stream_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_valid |-> (prim_count != '0 && ent_valid));

endmodule

// File: tb/mhr_entry_tb.sv
module mhr_entry_tb_top;
  import mhr_pkg::*;

  localparam int ADDR_W = 32;
  localparam int DEPTH  = 4;
  localparam int CNT_W  = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_alloc = 0, op_add = 0, op_issue = 0, op_snoop = 0, op_fill = 0;
  logic op_promote = 0, op_free = 0, op_below_set = 0, op_below_clr = 0;
  logic [ADDR_W-1:0] in_addr = '0;
  logic [2:0]        in_cmd = '0;
  logic [ORD_W-1:0]  in_ord = '0;
  logic rsp_shared = 0, rsp_inhibit = 0, snp_excl = 0, snp_inval = 0, snp_express = 0;
  logic fill_shared = 0, tgt_ready = 0;
  logic snp_absorb, snp_shared, snp_inhibit, tgt_valid;
  logic [2:0] tgt_cmd;
  logic [1:0] tgt_src;
  logic [ORD_W-1:0] tgt_ord, ent_ord;
  logic ent_valid, in_service, below_pending, pend_dirty, post_inval, post_down, op_err;
  logic [ADDR_W-1:0] ent_addr;
  logic [CNT_W-1:0] prim_count, def_count;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  mhr_entry #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) dut_i (
    .clk, .rst_n, .op_alloc, .op_add, .op_issue, .op_snoop, .op_fill, .op_promote,
    .op_free, .op_below_set, .op_below_clr, .in_addr, .in_cmd, .in_ord,
    .rsp_shared, .rsp_inhibit, .snp_excl, .snp_inval, .snp_express, .fill_shared,
    .snp_absorb, .snp_shared, .snp_inhibit, .tgt_valid, .tgt_ready, .tgt_cmd,
    .tgt_src, .tgt_ord, .ent_valid, .ent_addr, .ent_ord, .in_service, .below_pending,
    .pend_dirty, .post_inval, .post_down, .prim_count, .def_count, .op_err
  );

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // Strobes are driven after a falling edge; one rising edge later, sampling
  // happens at the next falling edge.
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_ops();
    op_alloc = 0; op_add = 0; op_issue = 0; op_snoop = 0; op_fill = 0;
    op_promote = 0; op_free = 0; op_below_set = 0; op_below_clr = 0;
  endtask

  task automatic do_alloc(int addr, int cmd, int ord);
    in_addr = ADDR_W'(addr); in_cmd = 3'(cmd); in_ord = ORD_W'(ord);
    op_alloc = 1; tick(); clear_ops();
  endtask

  task automatic do_add(int cmd, int ord);
    in_cmd = 3'(cmd); in_ord = ORD_W'(ord);
    op_add = 1; tick(); clear_ops();
  endtask

  task automatic do_issue(bit sh, bit inh);
    rsp_shared = sh; rsp_inhibit = inh;
    op_issue = 1; tick(); clear_ops();
  endtask

  task automatic do_snoop(string req, int cmd, int ord, bit ex, bit inv, bit expr,
                          int e_abs, int e_sh, int e_inh);
    in_cmd = 3'(cmd); in_ord = ORD_W'(ord);
    snp_excl = ex; snp_inval = inv; snp_express = expr;
    op_snoop = 1;
    #1;
    chk(req, "snoop absorb", int'(snp_absorb), e_abs);
    chk(req, "snoop shared", int'(snp_shared), e_sh);
    chk(req, "snoop inhibit", int'(snp_inhibit), e_inh);
    tick(); clear_ops();
    snp_excl = 0; snp_inval = 0; snp_express = 0;
  endtask

  task automatic do_fill(bit sh);
    fill_shared = sh; op_fill = 1; tick(); clear_ops(); fill_shared = 0;
  endtask

  task automatic do_promote();
    op_promote = 1; tick(); clear_ops();
  endtask

  task automatic do_free();
    op_free = 1; tick(); clear_ops();
  endtask

  task automatic pop_one(string req, int cmd, int src, int ord);
    tgt_ready = 1;
    #1;
    chk(req, "stream valid", int'(tgt_valid), 1);
    chk(req, "stream cmd", int'(tgt_cmd), cmd);
    chk(req, "stream src", int'(tgt_src), src);
    chk(req, "stream ord", int'(tgt_ord), ord);
    tick();
    tgt_ready = 0;
  endtask

  task automatic counts(string req, int p, int d);
    chk(req, "primary count", int'(prim_count), p);
    chk(req, "deferred count", int'(def_count), d);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk("R1", "valid after reset", int'(ent_valid), 0);
    chk("R11", "err after reset", int'(op_err), 0);
    chk("R13", "stream idle after reset", int'(tgt_valid), 0);
    counts("R14", 0, 0);
  endtask

  task automatic t_alloc_prefetch();
    do_alloc(32'h1000, 5, 5);
    chk("R1", "valid", int'(ent_valid), 1);
    chk("R1", "addr", int'(ent_addr), 32'h1000);
    chk("R1", "order", int'(ent_ord), 5);
    chk("R1", "in service", int'(in_service), 0);
    counts("R1", 1, 0);
    pop_one("R1", 5, 1, 5);
    chk("R13", "stream empty", int'(tgt_valid), 0);
    do_free();
    chk("R11", "freed", int'(ent_valid), 0);
    chk("R11", "no err on legal free", int'(op_err), 0);
  endtask

  task automatic t_illegal_free_alloc();
    do_alloc(32'h2000, 0, 1);
    do_free();
    chk("R11", "err on busy free", int'(op_err), 1);
    chk("R11", "still valid", int'(ent_valid), 1);
    counts("R11", 1, 0);
    do_alloc(32'h3000, 1, 9);
    chk("R1", "err on double alloc", int'(op_err), 1);
    chk("R1", "addr kept", int'(ent_addr), 32'h2000);
    chk("R1", "order kept", int'(ent_ord), 1);
    pop_one("R13", 0, 0, 1);
    do_free();
    chk("R11", "released", int'(ent_valid), 0);
  endtask

  task automatic t_route_and_merge();
    do_alloc(32'h40, 0, 1);
    do_issue(0, 0);
    chk("R4", "pending dirty clear", int'(pend_dirty), 0);
    do_add(0, 2);
    counts("R2", 2, 0);
    do_add(1, 3);
    counts("R2", 2, 1);
    do_add(0, 4);
    counts("R2", 2, 2);
    do_fill(1);
    counts("R10", 2, 2);
    do_fill(0);
    counts("R10", 4, 0);
    pop_one("R10", 0, 0, 1);
    pop_one("R10", 0, 0, 2);
    pop_one("R10", 1, 0, 3);
    pop_one("R10", 0, 0, 4);
    do_free();
    chk("R11", "released", int'(ent_valid), 0);
  endtask

  task automatic t_dirty_snoop_promote();
    do_alloc(32'h80, 0, 1);
    do_issue(0, 1);
    chk("R4", "dirty from inhibit", int'(pend_dirty), 1);
    do_add(1, 2);
    counts("R2", 2, 0);
    do_snoop("R7", 0, 9, 0, 0, 0, 1, 1, 1);
    chk("R8", "post downgrade", int'(post_down), 1);
    chk("R7", "no post invalidate", int'(post_inval), 0);
    counts("R7", 3, 0);
    do_add(1, 3);
    counts("R2", 3, 1);
    pop_one("R13", 0, 0, 1);
    pop_one("R13", 1, 0, 2);
    pop_one("R7", 0, 2, 9);
    do_promote();
    counts("R9", 1, 0);
    chk("R9", "order from head", int'(ent_ord), 3);
    chk("R9", "service cleared", int'(in_service), 0);
    do_issue(0, 0);
    chk("R4", "post downgrade cleared", int'(post_down), 0);
    chk("R4", "dirty from exclusive list", int'(pend_dirty), 1);
    pop_one("R9", 1, 0, 3);
    do_free();
  endtask

  task automatic t_early_snoops();
    do_alloc(32'hC0, 2, 1);
    do_snoop("R5", 1, 3, 1, 0, 0, 0, 0, 0);
    counts("R5", 1, 0);
    pop_one("R5", 1, 0, 1);
    do_free();
    do_alloc(32'hC4, 0, 1);
    op_below_set = 1; tick(); clear_ops();
    chk("R5", "below pending set", int'(below_pending), 1);
    do_issue(0, 0);
    do_snoop("R5", 0, 4, 0, 0, 1, 0, 0, 0);
    chk("R5", "no downgrade for express", int'(post_down), 0);
    do_snoop("R8", 0, 5, 0, 0, 0, 1, 1, 0);
    chk("R8", "downgrade set", int'(post_down), 1);
    counts("R8", 1, 0);
    op_below_clr = 1; tick(); clear_ops();
    chk("R5", "below pending cleared", int'(below_pending), 0);
    pop_one("R8", 0, 0, 1);
    do_free();
  endtask

  task automatic t_post_invalidate();
    do_alloc(32'h100, 0, 1);
    do_issue(0, 0);
    do_snoop("R7", 1, 9, 1, 1, 0, 1, 0, 0);
    chk("R7", "post invalidate", int'(post_inval), 1);
    counts("R7", 2, 0);
    do_add(2, 7);
    do_add(4, 8);
    counts("R3", 2, 2);
    do_snoop("R6", 0, 10, 0, 1, 0, 1, 0, 0);
    counts("R6", 2, 2);
    chk("R6", "no downgrade after invalidate", int'(post_down), 0);
    pop_one("R7", 0, 0, 1);
    pop_one("R7", 1, 2, 9);
    do_promote();
    chk("R9", "order", int'(ent_ord), 7);
    pop_one("R3", 1, 0, 7);
    pop_one("R3", 7, 0, 8);
    do_free();
  endtask

  task automatic t_deferred_rewrite();
    do_alloc(32'h140, 0, 1);
    do_issue(0, 0);
    do_add(2, 2);
    counts("R2", 1, 1);
    do_snoop("R6", 1, 5, 1, 0, 0, 1, 0, 0);
    chk("R6", "no invalidate without copy", int'(post_inval), 0);
    counts("R6", 1, 1);
    pop_one("R6", 0, 0, 1);
    do_promote();
    pop_one("R6", 1, 0, 2);
    do_free();
  endtask

  task automatic t_priority();
    do_alloc(32'h180, 0, 1);
    in_cmd = 3'd0; in_ord = 8'd2;
    op_snoop = 1; op_add = 1;
    #1;
    chk("R12", "snoop wins, early", int'(snp_absorb), 0);
    tick(); clear_ops();
    counts("R12", 1, 0);
    op_fill = 1; op_add = 1; tick(); clear_ops();
    counts("R12", 1, 0);
    in_addr = 32'h999;
    op_add = 1; op_alloc = 1; tick(); clear_ops();
    counts("R12", 2, 0);
    chk("R12", "alloc ignored no err", int'(op_err), 0);
    do_promote();
    chk("R9", "promote err", int'(op_err), 1);
    counts("R9", 2, 0);
    pop_one("R12", 0, 0, 1);
    pop_one("R12", 0, 0, 2);
    do_free();
  endtask

  task automatic t_capacity();
    do_alloc(32'h1C0, 0, 1);
    do_add(0, 2);
    do_add(0, 3);
    do_add(0, 4);
    counts("R14", 4, 0);
    do_add(0, 5);
    chk("R14", "full err", int'(op_err), 1);
    counts("R14", 4, 0);
    pop_one("R14", 0, 0, 1);
    pop_one("R14", 0, 0, 2);
    pop_one("R14", 0, 0, 3);
    pop_one("R14", 0, 0, 4);
    do_free();
    chk("R11", "released", int'(ent_valid), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_alloc_prefetch();
    t_illegal_free_alloc();
    t_route_and_merge();
    t_dirty_snoop_promote();
    t_early_snoops();
    t_post_invalidate();
    t_deferred_rewrite();
    t_priority();
    t_capacity();
    summary();
  end

endmodule